// File: doc/BRIEF.md
# Branch Return Target Classifier

This block sits beside the branch unit and looks at the 32-bit destination of an indirect branch-and-exchange. It decides whether the branch is an ordinary jump, a return from a secure function that previously called into the non-secure world, or a return from an exception. The decision is registered and appears one cycle after the request. For a function or exception return, a strobe goes to the matching return engine. For an ordinary jump, the block reports the address with its low bit cleared and, for the security-switching branch form, the destination security state.

Three inputs shape the decision. A strap says whether the security extension is built in. A mode flag says whether the core runs an exception handler or ordinary thread code. A per-request flag marks the security-switching branch form. With the extension present, the magic window reaches two values lower, 0xFEFFFFFE and 0xFEFFFFFF, and these mean function return. The exception-return window starts at 0xFF000000. Function-return magic works in both modes. Exception-return magic works only in handler mode; in thread mode the branch is ordinary and a suppression flag is raised.

Top module: `rtm_classifier`

## Requirements
- R1: While reset is high and in the cycle after it, `cls_valid`, `cls_onehot`, `fnret_go`, `excret_go`, `exc_suppressed` and `dest_secure` are all 0, and `branch_pc` is 0.
- R2: A cycle with `req_valid` low gives `cls_valid` = 0 and `cls_onehot` = 3'b000 on the following cycle.
- R3: A cycle with `req_valid` high gives `cls_valid` = 1 on the following cycle, with exactly one bit of `cls_onehot` set. Bit 0 means ordinary branch, bit 1 means secure function return, and bit 2 means exception return.
- R4: A target below 0xFEFFFFFE is always classed as ordinary (bit 0), whatever the strap, the mode and the branch form.
- R5: With `sec_ext_present` high, a target of 0xFEFFFFFE or 0xFEFFFFFF is classed as function return (bit 1) in both thread and handler mode, whatever bit 0 of the target.
- R6: With `sec_ext_present` low, a target of 0xFEFFFFFE or 0xFEFFFFFF is classed as ordinary; a function-return class never appears while the strap was low for that request.
- R7: A target at or above 0xFF000000 with `handler_mode` high is classed as exception return (bit 2), whatever the strap.
- R8: A target at or above 0xFF000000 with `handler_mode` low is classed as ordinary, with `exc_suppressed` = 1. `exc_suppressed` is 0 for every other request.
- R9: `dest_secure` is 1 only when the request had `sec_xfer` high, `sec_ext_present` high, an ordinary class, and target bit 0 = 1; otherwise it is 0.
- R10: `fnret_go` is high exactly in cycles where `cls_valid` is high with class bit 1, and `excret_go` exactly where class bit 2 is set.
- R11: `branch_pc` takes the request target with bit 0 forced to 0, one cycle after each request, and holds its value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Branch target is presented this cycle |
| req_target | input | 32 | Branch destination value |
| sec_xfer | input | 1 | Branch is the security-switching form |
| sec_ext_present | input | 1 | Security extension strap |
| handler_mode | input | 1 | Core is in handler mode |
| cls_valid | output | 1 | Classification result is valid |
| cls_onehot | output | 3 | One-hot class: 0 ordinary, 1 function return, 2 exception return |
| fnret_go | output | 1 | Request strobe to the function-return engine |
| excret_go | output | 1 | Request strobe to the exception-return engine |
| exc_suppressed | output | 1 | Exception-return magic ignored outside handler mode |
| dest_secure | output | 1 | Destination security state for an ordinary security-switching branch |
| branch_pc | output | 32 | Target with bit 0 cleared |

## Verification
Two of the block's decisions meet in one request when a security-switching branch targets 0xFEFFFFFF. The magic-window match and the low-bit security select both claim the request. The bench drives this value in both modes, with the strap high and low. With the strap high, the function-return class must win and `dest_secure` must stay 0. With the strap low, the ordinary class must apply and bit 0 must set `dest_secure` only when the strap allows it. The same overlap arises between mode gating and the security select for exception magic in thread mode. The bench produces it with thread-mode targets at 0xFFFFFFFF and `sec_xfer` high, and it expects the suppressed ordinary class with `dest_secure` following bit 0.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    localparam int unsigned TGT_W = 32;
    localparam logic [TGT_W-1:0] EXC_MAGIC_MIN = 32'hFF00_0000;
    localparam logic [TGT_W-1:0] FN_MAGIC_MIN  = 32'hFEFF_FFFE;
    localparam int unsigned CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 3'b000,
        CLS_PLAIN  = 3'b001,
        CLS_FNRET  = 3'b010,
        CLS_EXCRET = 3'b100
    } cls_e;

    typedef struct packed {
        cls_e cls;
        logic suppressed;
        logic dest_secure;
    } decision_t;

    function automatic logic at_or_above(input logic [TGT_W-1:0] v,
                                         input logic [TGT_W-1:0] lim);
        return v >= lim;
    endfunction

endpackage

// File: rtl/rtm_magic_detect.sv
module rtm_magic_detect
    import rtm_pkg::*;
#(
    parameter int unsigned W = TGT_W,
    parameter logic [W-1:0] EXC_MIN = EXC_MAGIC_MIN,
    parameter logic [W-1:0] FN_MIN  = FN_MAGIC_MIN
) (
    input  logic [W-1:0] target,
    input  logic         sec_ext,
    output logic         hit_exc,
    output logic         hit_fn
);
    localparam bit HAS_FN_WINDOW = (FN_MIN < EXC_MIN);

    assign hit_exc = (target >= EXC_MIN);

    generate
        if (HAS_FN_WINDOW) begin : g_fn_window
            logic above_fn_floor;
            assign above_fn_floor = (target >= FN_MIN);
            assign hit_fn = sec_ext & above_fn_floor & ~hit_exc;
        end else begin : g_no_fn_window
            logic unused_sec;
            assign unused_sec = sec_ext;
            assign hit_fn = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rtm_resolve.sv
module rtm_resolve
    import rtm_pkg::*;
(
    input  logic      hit_exc,
    input  logic      hit_fn,
    input  logic      handler,
    input  logic      sec_xfer,
    input  logic      sec_ext,
    input  logic      tgt_lsb,
    output decision_t dec
);
    always_comb begin
        dec = '{cls: CLS_PLAIN, suppressed: 1'b0, dest_secure: 1'b0};
        if (hit_fn) begin
            dec.cls = CLS_FNRET;
        end else if (hit_exc && handler) begin
            dec.cls = CLS_EXCRET;
        end else begin
            dec.cls         = CLS_PLAIN;
            dec.suppressed  = hit_exc;
            dec.dest_secure = sec_xfer & sec_ext & tgt_lsb;
        end
    end
endmodule

// File: rtl/rtm_out_reg.sv
module rtm_out_reg
    import rtm_pkg::*;
#(
    parameter int unsigned W = TGT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  decision_t    dec,
    input  logic [W-1:0] pc_in,
    output logic         v_q,
    output logic [CLS_W-1:0] cls_q,
    output logic         fn_go_q,
    output logic         exc_go_q,
    output logic         supp_q,
    output logic         dsec_q,
    output logic [W-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            v_q      <= 1'b0;
            cls_q    <= CLS_NONE;
            fn_go_q  <= 1'b0;
            exc_go_q <= 1'b0;
            supp_q   <= 1'b0;
            dsec_q   <= 1'b0;
            pc_q     <= '0;
        end else begin
            v_q      <= req_valid;
            cls_q    <= req_valid ? dec.cls : CLS_NONE;
            fn_go_q  <= req_valid && (dec.cls == CLS_FNRET);
            exc_go_q <= req_valid && (dec.cls == CLS_EXCRET);
            supp_q   <= req_valid & dec.suppressed;
            dsec_q   <= req_valid & dec.dest_secure;
            if (req_valid) begin
                pc_q <= {pc_in[W-1:1], 1'b0};
            end
        end
    end
endmodule

// File: rtl/rtm_classifier.sv
module rtm_classifier
    import rtm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_target,
    input  logic        sec_xfer,
    input  logic        sec_ext_present,
    input  logic        handler_mode,
    output logic        cls_valid,
    output logic [2:0]  cls_onehot,
    output logic        fnret_go,
    output logic        excret_go,
    output logic        exc_suppressed,
    output logic        dest_secure,
    output logic [31:0] branch_pc
);
    logic      hit_exc;
    logic      hit_fn;
    decision_t dec;

    rtm_magic_detect #(
        .W       (TGT_W),
        .EXC_MIN (EXC_MAGIC_MIN),
        .FN_MIN  (FN_MAGIC_MIN)
    ) u_detect (
        .target  (req_target),
        .sec_ext (sec_ext_present),
        .hit_exc (hit_exc),
        .hit_fn  (hit_fn)
    );

    rtm_resolve u_resolve (
        .hit_exc  (hit_exc),
        .hit_fn   (hit_fn),
        .handler  (handler_mode),
        .sec_xfer (sec_xfer),
        .sec_ext  (sec_ext_present),
        .tgt_lsb  (req_target[0]),
        .dec      (dec)
    );

    rtm_out_reg #(.W(TGT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .dec       (dec),
        .pc_in     (req_target),
        .v_q       (cls_valid),
        .cls_q     (cls_onehot),
        .fn_go_q   (fnret_go),
        .exc_go_q  (excret_go),
        .supp_q    (exc_suppressed),
        .dsec_q    (dest_secure),
        .pc_q      (branch_pc)
    );
endmodule

// File: rtl/rtm_classifier_checker.sv
module rtm_classifier_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_target,
    input logic        sec_ext_present,
    input logic        handler_mode,
    input logic        cls_valid,
    input logic [2:0]  cls_onehot,
    input logic        fnret_go,
    input logic        excret_go,
    input logic        exc_suppressed,
    input logic        dest_secure
);
    p_idle_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !cls_valid |-> (cls_onehot == 3'b000));

    p_one_class_r3: assert property (@(posedge clk) disable iff (rst)
        cls_valid |-> ($countones(cls_onehot) == 1));

    p_fn_window_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sec_ext_present && (req_target[31:1] == 31'h7F7F_FFFF))
        |=> cls_onehot[1]);

    p_no_fn_without_strap_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sec_ext_present) |=> !cls_onehot[1]);

    p_exc_handler_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && handler_mode && (req_target[31:24] == 8'hFF))
        |=> cls_onehot[2]);

    p_suppress_plain_r8: assert property (@(posedge clk) disable iff (rst)
        exc_suppressed |-> cls_onehot[0]);

    p_dsec_plain_r9: assert property (@(posedge clk) disable iff (rst)
        dest_secure |-> cls_onehot[0]);

    p_fn_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        fnret_go == (cls_valid && cls_onehot[1]));

    p_exc_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        excret_go == (cls_valid && cls_onehot[2]));
endmodule

bind rtm_classifier rtm_classifier_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_target      (req_target),
    .sec_ext_present (sec_ext_present),
    .handler_mode    (handler_mode),
    .cls_valid       (cls_valid),
    .cls_onehot      (cls_onehot),
    .fnret_go        (fnret_go),
    .excret_go       (excret_go),
    .exc_suppressed  (exc_suppressed),
    .dest_secure     (dest_secure)
);

// File: tb/rtm_classifier_tb.sv
module rtm_classifier_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_target;
    logic        sec_xfer;
    logic        sec_ext_present;
    logic        handler_mode;
    logic        cls_valid;
    logic [2:0]  cls_onehot;
    logic        fnret_go;
    logic        excret_go;
    logic        exc_suppressed;
    logic        dest_secure;
    logic [31:0] branch_pc;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] pc_model = 32'h0;

    always #2.5 clk = ~clk;

    rtm_classifier u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .sec_xfer(sec_xfer), .sec_ext_present(sec_ext_present),
        .handler_mode(handler_mode), .cls_valid(cls_valid),
        .cls_onehot(cls_onehot), .fnret_go(fnret_go), .excret_go(excret_go),
        .exc_suppressed(exc_suppressed), .dest_secure(dest_secure),
        .branch_pc(branch_pc)
    );

    // expected {valid, class[2:0], fn_go, exc_go, supp, dsec}
    function automatic logic [7:0] model(input logic v, input logic [31:0] t,
                                         input logic sx, input logic se,
                                         input logic hm);
        logic [2:0] c;
        logic s, d;
        if (!v) return 8'h00;
        s = 1'b0; d = 1'b0;
        if (se && (t == 32'hFEFF_FFFE || t == 32'hFEFF_FFFF)) c = 3'b010;
        else if (t >= 32'hFF00_0000 && hm) c = 3'b100;
        else begin
            c = 3'b001;
            s = (t >= 32'hFF00_0000);
            d = sx & se & t[0];
        end
        return {1'b1, c, c[1], c[2], s, d};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic v, input logic [31:0] t,
                                      input logic se, input logic hm);
        if (!v) return "R2";
        if (t < 32'hFEFF_FFFE) return "R4";
        if (t < 32'hFF00_0000) return se ? "R5" : "R6";
        return hm ? "R7" : "R8";
    endfunction

    task automatic apply(input logic v, input logic [31:0] t, input logic sx,
                         input logic se, input logic hm);
        logic [7:0] exp;
        logic [7:0] act;
        req_valid = v; req_target = t; sec_xfer = sx;
        sec_ext_present = se; handler_mode = hm;
        exp = model(v, t, sx, se, hm);
        if (v) pc_model = {t[31:1], 1'b0};
        @(negedge clk);
        act = {cls_valid, cls_onehot, fnret_go, excret_go, exc_suppressed, dest_secure};
        check(act[7:4] == exp[7:4], tag_for(v, t, se, hm), 64'(act[7:4]), 64'(exp[7:4]));
        check(act[3:2] == exp[3:2], "R10", 64'(act[3:2]), 64'(exp[3:2]));
        check(act[1] == exp[1], "R8", 64'(act[1]), 64'(exp[1]));
        check(act[0] == exp[0], "R9", 64'(act[0]), 64'(exp[0]));
        check(branch_pc == pc_model, "R11", 64'(branch_pc), 64'(pc_model));
        if (v) check($countones(cls_onehot) == 1, "R3", 64'(cls_onehot), 64'h1);
    endtask

    function automatic logic [31:0] pick_target();
        case ($urandom_range(0, 5))
            0: return 32'hFEFF_FFFE;
            1: return 32'hFEFF_FFFF;
            2: return 32'hFF00_0000 | ($urandom() & 32'h00FF_FFFF);
            3: return 32'hFEFF_FFF0 | ($urandom() & 32'hD);
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20171009));
        rst = 1'b1; req_valid = 1'b1; req_target = 32'hFFFF_FFFF;
        sec_xfer = 1'b1; sec_ext_present = 1'b1; handler_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check({cls_valid, cls_onehot, fnret_go, excret_go, exc_suppressed, dest_secure} == 8'h00,
              "R1", 64'({cls_valid, cls_onehot}), 64'h0);
        check(branch_pc == 32'h0, "R1", 64'(branch_pc), 64'h0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(cls_valid == 1'b0, "R1", 64'(cls_valid), 64'h0);

        // directed corners: function window against strap, mode, low bit
        for (int m = 0; m < 8; m++) begin
            apply(1'b1, 32'hFEFF_FFFE, m[0], m[1], m[2]);
            apply(1'b1, 32'hFEFF_FFFF, m[0], m[1], m[2]);
            apply(1'b1, 32'hFF00_0000, m[0], m[1], m[2]);
            apply(1'b1, 32'hFFFF_FFFF, m[0], m[1], m[2]);
            apply(1'b1, 32'hFEFF_FFFD, m[0], m[1], m[2]);
            apply(1'b0, 32'h1234_5679, m[0], m[1], m[2]);
        end
        apply(1'b1, 32'h0000_0001, 1'b1, 1'b1, 1'b0);
        apply(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            apply($urandom_range(0, 3) != 0, pick_target(), 1'($urandom()),
                  1'($urandom()), 1'($urandom()));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule